// File: doc/BRIEF.md
# PWM Synchronization Trigger Controller

This block decides when a PWM timer may copy its buffered register values into the active set. It takes two kinds of trigger. A software trigger comes from a register write to a software sync bit. A bank of external hardware trigger lines, each with its own enable bit, provides the rest. Every hardware line is brought into the system clock domain by a flop synchronizer. A rising edge on the synchronized line counts as a trigger only while the line's enable bit is set.

Each honored trigger gives a one-cycle synchronization request to the timer. The same trigger may also give a counter reinitialize request. The software bit and the hardware enable bits clear themselves under rules set by the mode inputs:

- The software bit clears on the counter's next loading point in most configurations.
- In two configurations it clears in the same cycle as its own trigger.
- A hardware enable bit clears on its own event, unless the sticky mode is selected. In sticky mode only a software write of 0 clears it.

The counter, the buffered registers and the output stage sit outside this block.

Top module: `pwm_sync_trig_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the software bit, all hardware enable bits, `sync_req` and `cnt_reinit_req` become 0 at that edge.
- R2: A write of 1 to the software bit (`sw_wr_en`=1, `sw_wr_data`=1) makes `sync_req` high for exactly one cycle, in the cycle after the write. A write of 0 clears the bit in the next cycle and makes no request.
- R3: In deferred mode the software bit reads 1 after a write of 1 and holds 1 while `load_pt` is low. The bit reads 0 in the cycle after `load_pt` is high. Deferred mode is either of these: `cfg_enh_mode`=0 with (`cfg_load_buffered`=1 or `cfg_reinit`=0), or `cfg_enh_mode`=1 with `cfg_sw_cnt_rst`=0.
- R4: In immediate mode the software bit reads 0 in the cycle after a write of 1, and `sync_req` still pulses. Immediate mode is either of these: `cfg_enh_mode`=0 with `cfg_load_buffered`=0 and `cfg_reinit`=1, or `cfg_enh_mode`=1 with `cfg_sw_cnt_rst`=1.
- R5: In deferred mode, a new write of 1 in the same cycle as a loading point that ends an active software synchronization keeps the bit at 1, and `sync_req` pulses again.
- R6: A rising edge on `hw_trig_in[i]` whose enable bit is 1 gives `sync_req` high in the third clock cycle after the line changes, for one cycle only. A line held high gives no further request.
- R7: A hardware edge whose enable bit is 0 gives no `sync_req`.
- R8: With `cfg_hw_sticky`=0, an enable bit reads 0 in the same cycle that its honored event raises `sync_req`. With `cfg_hw_sticky`=1, it stays 1 until a write of 0.
- R9: `cnt_reinit_req` pulses together with `sync_req` in two cases. In legacy mode (`cfg_enh_mode`=0) with `cfg_reinit`=1, it pulses for any trigger. In enhanced mode (`cfg_enh_mode`=1) with `cfg_sw_cnt_rst`=1, it pulses only when the trigger includes a software trigger. In every other case it stays 0.
- R10: A write to `hw_en_wr_en[i]` loads `hw_en_wr_data[i]` into enable bit i in the next cycle. This write takes priority over an automatic clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_wr_en | input | 1 | Write strobe for the software sync bit |
| sw_wr_data | input | 1 | Value written to the software sync bit |
| hw_en_wr_en | input | N_HW | Per-line write strobes for the hardware enable bits |
| hw_en_wr_data | input | N_HW | Values written to the hardware enable bits |
| cfg_enh_mode | input | 1 | 1 selects enhanced synchronization mode |
| cfg_load_buffered | input | 1 | Legacy mode: buffered updates wait for a loading point |
| cfg_reinit | input | 1 | Legacy mode: triggers reinitialize the counter |
| cfg_sw_cnt_rst | input | 1 | Enhanced mode: software trigger reinitializes the counter |
| cfg_hw_sticky | input | 1 | 1 keeps the hardware enable bits set after events |
| hw_trig_in | input | N_HW | Raw asynchronous hardware trigger lines |
| load_pt | input | 1 | One-cycle loading-point pulse from the counter |
| sw_bit_q | output | 1 | Software sync bit readback |
| hw_en_q | output | N_HW | Hardware enable bit readback |
| sync_req | output | 1 | One-cycle synchronization request |
| cnt_reinit_req | output | 1 | One-cycle counter reinitialize request |

## Verification
The software trigger is swept over all sixteen combinations of the four mode inputs. This separates deferred clearing from immediate clearing, and shows which combinations also request a counter reinitialize. Each hardware line is driven with a rising edge, a held-high level, an edge while disabled, and an edge that meets a write in the same cycle. These cases separate the synchronizer latency, edge-only detection, enable gating and write priority. Each hardware line is tried in both sticky and non-sticky modes. A write of 1 that lands on a loading point shows that retriggering wins over the completion clear.

// File: rtl/pwm_trig_pkg.sv
// Package: shared configuration type and mode decoding for the PWM
// synchronization trigger controller.
package pwm_trig_pkg;

    // Mode inputs gathered into one word.
    typedef struct packed {
        logic enh_mode;
        logic load_buffered;
        logic reinit;
        logic sw_cnt_rst;
        logic hw_sticky;
    } trig_cfg_t;

    // True when the software bit clears in the same cycle as its trigger.
    function automatic logic sw_clear_on_event(trig_cfg_t c);
        return c.enh_mode ? c.sw_cnt_rst : (!c.load_buffered && c.reinit);
    endfunction

    // True when a trigger of the given kind must reinitialize the counter.
    function automatic logic needs_reinit(trig_cfg_t c, logic is_sw);
        return c.enh_mode ? (c.sw_cnt_rst && is_sw) : c.reinit;
    endfunction

endpackage

// File: rtl/trig_sync_edge.sv
// Module: trig_sync_edge
// Brings one asynchronous trigger line into the clock domain through a
// chain of STAGES flops, then flags its rising edge with one extra flop.
// Assumes STAGES >= 2. The edge flag is high for one cycle, and goes high
// STAGES clock edges after the line changes.
module trig_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic rise
);
    localparam int LAST = STAGES;

    logic [LAST:0] chain_q;

    // Shift the raw line through the synchronizer and the edge flop.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[LAST-1:0], raw};
    end

    assign rise = chain_q[LAST-1] & ~chain_q[LAST];

    // R6: an edge flag never lasts more than one cycle
    p_single_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/sw_trig_bit.sv
// Module: sw_trig_bit
// Holds the software sync bit. A write of 1 is a trigger event. In
// deferred mode the bit stays set until a loading point. In immediate
// mode it drops at once. A write always wins over the loading-point clear,
// so a retrigger in the completion cycle keeps the bit set.
module sw_trig_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_data,
    input  logic load_pt,
    input  logic clr_on_evt,
    output logic bit_q,
    output logic evt
);
    assign evt = wr_en & wr_data;

    // Update the bit from writes and loading points.
    always_ff @(posedge clk) begin
        if (!rst_n)       bit_q <= 1'b0;
        else if (wr_en)   bit_q <= wr_data & ~clr_on_evt;
        else if (load_pt) bit_q <= 1'b0;
    end

    // R2: a write of 0 clears the bit
    p_write_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data) |=> !bit_q);
    // R3: without a write or loading point the bit holds
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_q && !wr_en && !load_pt) |=> bit_q);
    // R3: a loading point ends the software synchronization
    p_load_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_q && !wr_en && load_pt) |=> !bit_q);
    // R4: immediate mode leaves the bit clear after a trigger
    p_imm_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && clr_on_evt) |=> !bit_q);
    // R5: a retrigger on a loading point keeps the bit set
    p_retrig_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && !clr_on_evt && load_pt) |=> bit_q);

endmodule

// File: rtl/hw_trig_bank.sv
// Module: hw_trig_bank
// N_HW identical hardware trigger lanes. Each lane synchronizes its line,
// detects the rising edge and honors it only while its enable bit is set.
// In non-sticky mode the enable bit clears on its own honored event.
// Writes from the bus take priority over that clear.
module hw_trig_bank #(
    parameter int N_HW   = 3,
    parameter int STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_HW-1:0] wr_en,
    input  logic [N_HW-1:0] wr_data,
    input  logic            sticky,
    input  logic [N_HW-1:0] raw,
    output logic [N_HW-1:0] en_q,
    output logic [N_HW-1:0] honored
);
    logic [N_HW-1:0] rise;

    for (genvar i = 0; i < N_HW; i++) begin : g_lane
        trig_sync_edge #(.STAGES(STAGES)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .raw  (raw[i]),
            .rise (rise[i])
        );

        assign honored[i] = rise[i] & en_q[i];

        // Maintain the lane's enable bit.
        always_ff @(posedge clk) begin
            if (!rst_n)                     en_q[i] <= 1'b0;
            else if (wr_en[i])              en_q[i] <= wr_data[i];
            else if (honored[i] && !sticky) en_q[i] <= 1'b0;
        end

        // R8: sticky mode keeps the bit against events
        p_sticky_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (en_q[i] && !wr_en[i] && sticky) |=> en_q[i]);
        // R8: non-sticky mode clears the bit on its event
        p_auto_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (rise[i] && en_q[i] && !wr_en[i] && !sticky) |=> !en_q[i]);
        // R10: a write loads its value
        p_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en[i] |=> (en_q[i] == $past(wr_data[i])));
    end

endmodule

// File: rtl/sync_req_gen.sv
// Module: sync_req_gen
// Merges the software event and the honored hardware events into one
// registered synchronization request. It also decides whether the counter
// must be reinitialized. Several triggers in one cycle give one pulse.
module sync_req_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_evt,
    input  logic hw_evt,
    input  logic reinit_sw,
    input  logic reinit_hw,
    output logic sync_req,
    output logic reinit_req
);
    // Register the request pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_req   <= 1'b0;
            reinit_req <= 1'b0;
        end else begin
            sync_req   <= sw_evt | hw_evt;
            reinit_req <= (sw_evt & reinit_sw) | (hw_evt & reinit_hw);
        end
    end

    // R9: reinitialize only accompanies a synchronization
    p_reinit_sub_r9: assert property (@(posedge clk) disable iff (!rst_n)
        reinit_req |-> sync_req);
    // R2: a software event always requests synchronization
    p_sw_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sw_evt |=> sync_req);

endmodule

// File: rtl/pwm_sync_trig_ctrl.sv
// Module: pwm_sync_trig_ctrl (top)
// PWM synchronization trigger controller. Combines the software sync bit,
// the hardware trigger bank and the request generator. Assumes that
// load_pt is a one-cycle pulse from the counter and that the mode inputs
// are quasi-static.
module pwm_sync_trig_ctrl
    import pwm_trig_pkg::*;
#(
    parameter int N_HW   = 3,
    parameter int STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sw_wr_en,
    input  logic            sw_wr_data,
    input  logic [N_HW-1:0] hw_en_wr_en,
    input  logic [N_HW-1:0] hw_en_wr_data,
    input  logic            cfg_enh_mode,
    input  logic            cfg_load_buffered,
    input  logic            cfg_reinit,
    input  logic            cfg_sw_cnt_rst,
    input  logic            cfg_hw_sticky,
    input  logic [N_HW-1:0] hw_trig_in,
    input  logic            load_pt,
    output logic            sw_bit_q,
    output logic [N_HW-1:0] hw_en_q,
    output logic            sync_req,
    output logic            cnt_reinit_req
);
    trig_cfg_t       cfg;
    logic            sw_evt;
    logic [N_HW-1:0] hw_honored;

    assign cfg = '{enh_mode:      cfg_enh_mode,
                   load_buffered: cfg_load_buffered,
                   reinit:        cfg_reinit,
                   sw_cnt_rst:    cfg_sw_cnt_rst,
                   hw_sticky:     cfg_hw_sticky};

    sw_trig_bit u_sw (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (sw_wr_en),
        .wr_data   (sw_wr_data),
        .load_pt   (load_pt),
        .clr_on_evt(sw_clear_on_event(cfg)),
        .bit_q     (sw_bit_q),
        .evt       (sw_evt)
    );

    hw_trig_bank #(.N_HW(N_HW), .STAGES(STAGES)) u_hw (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (hw_en_wr_en),
        .wr_data(hw_en_wr_data),
        .sticky (cfg.hw_sticky),
        .raw    (hw_trig_in),
        .en_q   (hw_en_q),
        .honored(hw_honored)
    );

    sync_req_gen u_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .sw_evt    (sw_evt),
        .hw_evt    (|hw_honored),
        .reinit_sw (needs_reinit(cfg, 1'b1)),
        .reinit_hw (needs_reinit(cfg, 1'b0)),
        .sync_req  (sync_req),
        .reinit_req(cnt_reinit_req)
    );

    // R7: no software write and no enabled line means no request
    p_disabled_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!(sw_wr_en && sw_wr_data) && hw_en_q == '0) |=> !sync_req);
    // R9: legacy mode without reinit never reinitializes
    p_no_reinit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_enh_mode && !cfg_reinit) |=> !cnt_reinit_req);
    // R1: reset clears the readback state
    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (!sw_bit_q && hw_en_q == '0 && !sync_req && !cnt_reinit_req));

endmodule

// File: tb/pwm_sync_trig_ctrl_tb_top.sv
module pwm_sync_trig_ctrl_tb_top;
    localparam int N = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sw_wr_en = 1'b0, sw_wr_data = 1'b0;
    logic [N-1:0] hw_en_wr_en = '0, hw_en_wr_data = '0;
    logic         cfg_enh_mode = 1'b0, cfg_load_buffered = 1'b0, cfg_reinit = 1'b0;
    logic         cfg_sw_cnt_rst = 1'b0, cfg_hw_sticky = 1'b0;
    logic [N-1:0] hw_trig_in = '0;
    logic         load_pt = 1'b0;
    logic         sw_bit_q, sync_req, cnt_reinit_req;
    logic [N-1:0] hw_en_q;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    pwm_sync_trig_ctrl #(.N_HW(N), .STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data),
        .hw_en_wr_en(hw_en_wr_en), .hw_en_wr_data(hw_en_wr_data),
        .cfg_enh_mode(cfg_enh_mode), .cfg_load_buffered(cfg_load_buffered),
        .cfg_reinit(cfg_reinit), .cfg_sw_cnt_rst(cfg_sw_cnt_rst),
        .cfg_hw_sticky(cfg_hw_sticky), .hw_trig_in(hw_trig_in),
        .load_pt(load_pt), .sw_bit_q(sw_bit_q), .hw_en_q(hw_en_q),
        .sync_req(sync_req), .cnt_reinit_req(cnt_reinit_req)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One clock: outputs are sampled and inputs changed at the negedge.
    task automatic step();
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        // R1: reset state
        hw_trig_in = '1;
        sw_wr_en = 1'b1; sw_wr_data = 1'b1;
        repeat (4) step();
        chk("R1 sw bit", sw_bit_q, 0);
        chk("R1 hw bits", hw_en_q, 0);
        chk("R1 sync", sync_req, 0);
        chk("R1 reinit", cnt_reinit_req, 0);
        hw_trig_in = '0; sw_wr_en = 1'b0; sw_wr_data = 1'b0;
        repeat (4) step();
        rst_n = 1'b1;
        step();
        chk("R1 after release", {sw_bit_q, hw_en_q, sync_req}, 0);

        // Software trigger over every mode combination
        for (int m = 0; m < 16; m++) begin
            logic imm, exp_bit, exp_ri;
            {cfg_enh_mode, cfg_load_buffered, cfg_reinit, cfg_sw_cnt_rst} = 4'(m);
            imm     = cfg_enh_mode ? cfg_sw_cnt_rst : (!cfg_load_buffered && cfg_reinit);
            exp_bit = !imm;
            exp_ri  = cfg_enh_mode ? cfg_sw_cnt_rst : cfg_reinit;
            step();
            sw_wr_en = 1'b1; sw_wr_data = 1'b1;
            step();
            sw_wr_en = 1'b0;
            chk("R2 sync pulse", sync_req, 1);
            chk("R9 sw reinit", cnt_reinit_req, 32'(exp_ri));
            chk(imm ? "R4 immediate clear" : "R3 bit set", sw_bit_q, 32'(exp_bit));
            step();
            chk("R2 single pulse", sync_req, 0);
            step();
            chk("R3 hold before load", sw_bit_q, 32'(exp_bit));
            load_pt = 1'b1;
            step();
            load_pt = 1'b0;
            chk("R3 clear at load", sw_bit_q, 0);
            // R5: retrigger at the completion loading point
            sw_wr_en = 1'b1; sw_wr_data = 1'b1;
            step();
            sw_wr_data = 1'b1; load_pt = 1'b1;
            step();
            sw_wr_en = 1'b0; load_pt = 1'b0;
            chk("R5 retrigger bit", sw_bit_q, 32'(exp_bit));
            chk("R5 retrigger sync", sync_req, 1);
            sw_wr_en = 1'b1; sw_wr_data = 1'b0;
            step();
            sw_wr_en = 1'b0;
            chk("R2 write zero", sw_bit_q, 0);
            chk("R2 write zero no sync", sync_req, 0);
        end

        // Hardware lanes, non-sticky and sticky
        for (int s = 0; s < 2; s++) begin
            for (int i = 0; i < N; i++) begin
                cfg_hw_sticky = s[0];
                cfg_enh_mode = 1'b0; cfg_reinit = i[0]; cfg_load_buffered = 1'b1;
                hw_en_wr_en = N'(1) << i; hw_en_wr_data = N'(1) << i;
                step();
                hw_en_wr_en = '0;
                chk("R10 enable write", hw_en_q, N'(1) << i);
                hw_trig_in[i] = 1'b1;
                step();
                chk("R6 latency A", sync_req, 0);
                step();
                chk("R6 latency B", sync_req, 0);
                step();
                chk("R6 request", sync_req, 1);
                chk("R9 hw reinit", cnt_reinit_req, 32'(i[0]));
                chk("R8 enable after event", hw_en_q, s[0] ? (N'(1) << i) : '0);
                for (int k = 0; k < 3; k++) begin
                    step();
                    chk("R6 held high no repeat", sync_req, 0);
                end
                hw_trig_in[i] = 1'b0;
                repeat (4) step();
                hw_en_wr_en = N'(1) << i; hw_en_wr_data = '0;
                step();
                hw_en_wr_en = '0;
                chk("R8 write zero clears", hw_en_q, 0);
            end
        end

        // R7: edges on disabled lines
        cfg_hw_sticky = 1'b0;
        hw_trig_in = '1;
        for (int k = 0; k < 5; k++) begin
            step();
            chk("R7 disabled no sync", sync_req, 0);
        end
        chk("R7 bits untouched", hw_en_q, 0);
        hw_trig_in = '0;
        repeat (4) step();

        // R10: a write in the event cycle wins over the automatic clear
        hw_en_wr_en = 'b1; hw_en_wr_data = 'b1;
        step();
        hw_en_wr_en = '0;
        hw_trig_in[0] = 1'b1;
        step();
        step();
        hw_en_wr_en = 'b1; hw_en_wr_data = 'b1;
        step();
        hw_en_wr_en = '0;
        chk("R10 write priority sync", sync_req, 1);
        chk("R10 write priority bit", hw_en_q, 1);
        hw_trig_in = '0;
        repeat (4) step();

        // R9: enhanced mode hardware trigger gives no reinit
        cfg_enh_mode = 1'b1; cfg_sw_cnt_rst = 1'b1;
        hw_trig_in[0] = 1'b1;
        repeat (3) step();
        chk("R9 enhanced hw sync", sync_req, 1);
        chk("R9 enhanced hw no reinit", cnt_reinit_req, 0);

        finish_run();
    end
endmodule